// File: doc/BRIEF.md
# Dual-Bus Quiet Detector and Link Arbiter

This block sits in one half of an isolated two-wire bus bridge. It decides when the local bus may be tied to the logic state of the bus on the far side of the isolation barrier. It watches the local SDA/SCL pins through a synchroniser. It also watches the far-side SDA/SCL levels that the link decoder delivers in the clock domain. A bus counts as quiet in two cases. The first is that both of its lines have stayed high for a programmable number of clock cycles. The second is that a STOP condition has been seen and both lines have stayed high ever since. The link is granted only when the two buses are quiet at the same time.

After power comes up (enable high and no thermal shutdown), the transmit path is switched on in the next cycle. The receive path is held off for a programmable start-up interval. Until that interval ends, the far bus is treated as not quiet. Once granted, the link holds through normal traffic. It is withdrawn at once by loss of power, thermal shutdown, a stuck-bus fault or a receive timeout. The ready output is the active-low copy of the link state. Reconnection after any fault needs a fresh STOP or a fresh idle interval on both buses.

Top module: `qlink_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, link_active_o=0, ready_n_o=1, tx_en_o=0 and rx_en_o=0.
- R2: tx_en_o equals (en_i & !therm_i) as sampled one clock earlier.
- R3: rx_en_o goes high HOLD_CYC+1 cycles after power becomes valid. It drops in the cycle after power is lost.
- R4: A bus whose SDA and SCL have both been high for IDLE_CYC consecutive samples counts as quiet.
- R5: SDA rising while SCL is high (a STOP), followed by both lines high, makes a bus quiet without waiting for the idle interval.
- R6: The link is granted only when the local and the remote bus are quiet in the same cycle. One quiet bus alone never grants it.
- R7: Remote line levels are ignored while rx_en_o is low. The remote bus then counts as not quiet, and its idle interval starts only once receive is enabled.
- R8: Any low sample on SDA or SCL of a bus clears that bus's idle count and its quiet state.
- R9: Once granted, the link stays active through bus traffic on either side until a fault or power loss occurs.
- R10: ready_n_o is low exactly when link_active_o is high.
- R11: stuck_i, rxto_i, therm_i high or en_i low drops link_active_o in the next cycle.
- R12: After a fault clears, the link returns only after a new STOP or a full idle interval on both buses.
- R13: SDA rising while SCL is low is not a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Device enable (power valid when high) |
| therm_i | input | 1 | Thermal shutdown in progress |
| stuck_i | input | 1 | Stuck-bus fault flag |
| rxto_i | input | 1 | Receive-timeout fault flag |
| loc_sda_i | input | 1 | Local SDA level (asynchronous) |
| loc_scl_i | input | 1 | Local SCL level (asynchronous) |
| rem_sda_i | input | 1 | Decoded remote SDA level |
| rem_scl_i | input | 1 | Decoded remote SCL level |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive decoding enable |
| link_active_o | output | 1 | Local lines follow remote state |
| ready_n_o | output | 1 | Active-low ready indication |

## Verification
The bench grants the link in three ways: by idle time on both buses, by a STOP on both buses, and by a STOP on one bus after the other has gone quiet through idle time. These show that each qualification path works alone and that the two buses are combined with AND. The bench also tries patterns that must not grant the link. These are a lone quiet bus, a remote bus that is high only during the receive holdoff, idle intervals broken by single-cycle low glitches, and SDA rising under a low SCL. They catch a detector that treats either bus as sufficient, ignores the receive gate, fails to restart its count, or takes any SDA rise for a STOP. Fault pulses of each kind check that the link drops and that it does not return before requalification.

// File: rtl/qlink_pkg.sv
package qlink_pkg;
  typedef enum logic [1:0] {
    LS_OFF  = 2'd0,
    LS_WAIT = 2'd1,
    LS_LINK = 2'd2
  } link_state_t;
endpackage

// File: rtl/qlink_sync.sv
module qlink_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] chain_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
        end else begin
          chain_q[0] <= d_i;
          for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/qlink_quiet.sv
module qlink_quiet #(
  parameter int IDLE_CYC = 23000
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic quiet_o
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LIM   = CW'(IDLE_CYC);
  localparam logic [CW-1:0] LIM_M = CW'(IDLE_CYC - 1);

  logic          sda_q, scl_q, stop_seen_q, quiet_q;
  logic [CW-1:0] idle_cnt_q;
  logic          stop_ev;

  // STOP: SDA low->high while SCL stays high across both samples
  assign stop_ev = !sda_q && scl_q && sda_i && scl_i;

  always_ff @(posedge clk) begin
    if (rst || !valid_i) begin
      sda_q       <= 1'b1;
      scl_q       <= 1'b1;
      idle_cnt_q  <= '0;
      stop_seen_q <= 1'b0;
      quiet_q     <= 1'b0;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
      if (!sda_i || !scl_i) begin
        idle_cnt_q  <= '0;
        stop_seen_q <= 1'b0;
        quiet_q     <= 1'b0;
      end else begin
        if (idle_cnt_q != LIM) idle_cnt_q <= idle_cnt_q + 1'b1;
        if (stop_ev) stop_seen_q <= 1'b1;
        quiet_q <= stop_ev || stop_seen_q || (idle_cnt_q >= LIM_M);
      end
    end
  end

  assign quiet_o = quiet_q;

  a_r8_low_clears_quiet: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (!sda_i || !scl_i)) |=> !quiet_o);
  a_r7_invalid_not_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !quiet_o);
endmodule

// File: rtl/qlink_holdoff.sv
module qlink_holdoff #(
  parameter int HOLD_CYC = 180000
) (
  input  logic clk,
  input  logic rst,
  input  logic powered_i,
  output logic tx_en_o,
  output logic rx_en_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HLIM = HW'(HOLD_CYC);

  logic [HW-1:0] hold_cnt_q;
  logic          tx_q, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt_q <= '0;
      tx_q       <= 1'b0;
      rx_q       <= 1'b0;
    end else begin
      tx_q <= powered_i;
      if (!powered_i) begin
        hold_cnt_q <= '0;
        rx_q       <= 1'b0;
      end else begin
        if (hold_cnt_q != HLIM) hold_cnt_q <= hold_cnt_q + 1'b1;
        rx_q <= (hold_cnt_q == HLIM);
      end
    end
  end

  assign tx_en_o = tx_q;
  assign rx_en_o = rx_q;

  a_r2_tx_follows_power: assert property (@(posedge clk) disable iff (rst)
    powered_i |=> tx_en_o);
  a_r3_rx_off_unpowered: assert property (@(posedge clk) disable iff (rst)
    !powered_i |=> !rx_en_o);
  a_r3_rx_after_hold: assert property (@(posedge clk) disable iff (rst)
    rx_en_o |-> (hold_cnt_q == HLIM));
endmodule

// File: rtl/qlink_arbiter.sv
module qlink_arbiter #(
  parameter int IDLE_CYC = 23000,
  parameter int HOLD_CYC = 180000,
  parameter int LOC_SYNC = 2,
  parameter int REM_SYNC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic therm_i,
  input  logic stuck_i,
  input  logic rxto_i,
  input  logic loc_sda_i,
  input  logic loc_scl_i,
  input  logic rem_sda_i,
  input  logic rem_scl_i,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic link_active_o,
  output logic ready_n_o
);
  import qlink_pkg::*;

  logic        powered, fault_any, loc_valid, rem_valid;
  logic        loc_quiet, rem_quiet;
  logic [1:0]  loc_lines, rem_lines;
  link_state_t st_q, st_d;
  logic        link_q, ready_n_q;

  assign powered   = en_i && !therm_i;
  assign fault_any = !powered || stuck_i || rxto_i || !rx_en_o;
  assign loc_valid = powered && !stuck_i && !rxto_i;
  assign rem_valid = rx_en_o && !stuck_i && !rxto_i;

  qlink_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .powered_i(powered),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o));

  qlink_sync #(.STAGES(LOC_SYNC), .WIDTH(2)) u_loc_sync (
    .clk(clk), .rst(rst), .d_i({loc_sda_i, loc_scl_i}), .q_o(loc_lines));

  qlink_sync #(.STAGES(REM_SYNC), .WIDTH(2)) u_rem_sync (
    .clk(clk), .rst(rst), .d_i({rem_sda_i, rem_scl_i}), .q_o(rem_lines));

  qlink_quiet #(.IDLE_CYC(IDLE_CYC)) u_loc_quiet (
    .clk(clk), .rst(rst), .valid_i(loc_valid),
    .sda_i(loc_lines[1]), .scl_i(loc_lines[0]), .quiet_o(loc_quiet));

  qlink_quiet #(.IDLE_CYC(IDLE_CYC)) u_rem_quiet (
    .clk(clk), .rst(rst), .valid_i(rem_valid),
    .sda_i(rem_lines[1]), .scl_i(rem_lines[0]), .quiet_o(rem_quiet));

  always_comb begin
    st_d = st_q;
    if (fault_any) begin
      st_d = LS_OFF;
    end else begin
      case (st_q)
        LS_OFF:  st_d = LS_WAIT;
        LS_WAIT: if (loc_quiet && rem_quiet) st_d = LS_LINK;
        LS_LINK: st_d = LS_LINK;
        default: st_d = LS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= LS_OFF;
      link_q    <= 1'b0;
      ready_n_q <= 1'b1;
    end else begin
      st_q      <= st_d;
      link_q    <= (st_d == LS_LINK);
      ready_n_q <= (st_d != LS_LINK);
    end
  end

  assign link_active_o = link_q;
  assign ready_n_o     = ready_n_q;

  a_r6_grant_needs_both: assert property (@(posedge clk) disable iff (rst)
    $rose(link_active_o) |-> $past(loc_quiet && rem_quiet));
  a_r11_fault_drops: assert property (@(posedge clk) disable iff (rst)
    (stuck_i || rxto_i || !powered) |=> !link_active_o);
  a_r7_link_needs_rx: assert property (@(posedge clk) disable iff (rst)
    link_active_o |-> rx_en_o);
  a_r10_ready_polarity: assert property (@(posedge clk) disable iff (rst)
    ready_n_o != link_active_o);
endmodule

// File: tb/qlink_arbiter_tb_top.sv
`timescale 1ns/1ps
module qlink_arbiter_tb_top;
  localparam int IDLE = 32;
  localparam int HOLD = 50;

  logic clk = 1'b0;
  logic rst, en, therm, stuck, rxto;
  logic lsda, lscl, rsda, rscl;
  logic tx_en, rx_en, link, ready_n;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  qlink_arbiter #(.IDLE_CYC(IDLE), .HOLD_CYC(HOLD), .LOC_SYNC(2), .REM_SYNC(1)) dut_i (
    .clk(clk), .rst(rst), .en_i(en), .therm_i(therm), .stuck_i(stuck),
    .rxto_i(rxto), .loc_sda_i(lsda), .loc_scl_i(lscl),
    .rem_sda_i(rsda), .rem_scl_i(rscl), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .link_active_o(link), .ready_n_o(ready_n));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 4 * HOLD && !rx_en; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; en = 0; therm = 0; stuck = 0; rxto = 0;
    lsda = 1; lscl = 1; rsda = 1; rscl = 1;
    cyc(3);
    chk(link, 1'b0, "R1 link in reset");
    chk(ready_n, 1'b1, "R1 ready_n in reset");
    chk(tx_en, 1'b0, "R1 tx_en in reset");
    rst = 0;
    cyc(1);
    chk(rx_en, 1'b0, "R1 rx_en after reset");
  endtask

  task automatic t_powerup();
    chk(tx_en, 1'b0, "R2 tx_en before enable");
    en = 1;
    cyc(1);
    chk(tx_en, 1'b1, "R2 tx_en one cycle after enable");
    cyc(HOLD - 4);
    chk(rx_en, 1'b0, "R3 rx_en held off");
    chk(link, 1'b0, "R7 no link during holdoff");
    cyc(8);
    chk(rx_en, 1'b1, "R3 rx_en after holdoff");
    chk(link, 1'b0, "R7 remote high during holdoff not counted");
    cyc(IDLE - 8);
    chk(link, 1'b0, "R4 remote idle not yet elapsed");
    cyc(12);
    chk(link, 1'b1, "R4 link after idle on both buses");
    chk(ready_n, 1'b0, "R10 ready_n low when linked");
  endtask

  task automatic t_traffic();
    lscl = 0; cyc(3); lsda = 0; cyc(3);
    chk(link, 1'b1, "R9 link held during local traffic");
    rscl = 0; cyc(3); rsda = 0; cyc(3); rscl = 1; cyc(3);
    chk(link, 1'b1, "R9 link held during remote traffic");
    chk(ready_n, 1'b0, "R10 ready_n during traffic");
    lscl = 1; cyc(3); lsda = 1; rsda = 1; cyc(3);
  endtask

  task automatic t_stuck();
    stuck = 1;
    cyc(1);
    chk(link, 1'b0, "R11 stuck fault drops link");
    chk(ready_n, 1'b1, "R10 ready_n high after drop");
    stuck = 0;
    cyc(IDLE - 4);
    chk(link, 1'b0, "R12 no relink before fresh idle");
    cyc(10);
    chk(link, 1'b1, "R12 relink after fresh idle");
  endtask

  task automatic t_stop();
    rxto = 1;
    cyc(1);
    chk(link, 1'b0, "R11 rx timeout drops link");
    lsda = 0; rsda = 0;
    cyc(3);
    rxto = 0;
    cyc(5);
    lsda = 1; rsda = 1;
    cyc(8);
    chk(link, 1'b1, "R5 STOP on both buses relinks early");
  endtask

  task automatic t_sda_under_low_scl();
    stuck = 1;
    lsda = 0; lscl = 0; rsda = 0; rscl = 0;
    cyc(2);
    stuck = 0;
    cyc(5);
    lsda = 1; rsda = 1;
    cyc(3);
    lscl = 1; rscl = 1;
    cyc(8);
    chk(link, 1'b0, "R13 SDA rise with SCL low is no STOP");
    cyc(IDLE);
    chk(link, 1'b1, "R13 link after idle instead");
  endtask

  task automatic t_glitches();
    stuck = 1;
    cyc(2);
    stuck = 0;
    for (int k = 0; k < 4; k++) begin
      cyc(IDLE - 8);
      lscl = 0;
      cyc(1);
      lscl = 1;
    end
    cyc(2);
    chk(link, 1'b0, "R8 low glitches restart idle count");
    cyc(IDLE + 6);
    chk(link, 1'b1, "R8 link after unbroken idle");
  endtask

  task automatic t_one_bus();
    stuck = 1;
    rsda = 0;
    cyc(2);
    stuck = 0;
    cyc(2 * IDLE);
    chk(link, 1'b0, "R6 local quiet alone gives no link");
    rsda = 1;
    cyc(6);
    chk(link, 1'b1, "R6 link once remote STOP joins");
  endtask

  task automatic t_power_loss();
    therm = 1;
    cyc(1);
    chk(link, 1'b0, "R11 thermal shutdown drops link");
    chk(tx_en, 1'b0, "R2 tx_en off in thermal shutdown");
    chk(rx_en, 1'b0, "R3 rx_en off in thermal shutdown");
    therm = 0;
    cyc(HOLD - 4);
    chk(rx_en, 1'b0, "R3 holdoff repeats after shutdown");
    wait_rx();
    cyc(IDLE + 6);
    chk(link, 1'b1, "R12 relink after shutdown clears");
    en = 0;
    cyc(1);
    chk(link, 1'b0, "R11 enable low drops link");
    chk(tx_en, 1'b0, "R2 tx_en off when disabled");
    en = 1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_powerup();
    t_traffic();
    t_stuck();
    t_stop();
    t_sda_under_low_scl();
    t_glitches();
    t_one_bus();
    t_power_loss();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule